// File: doc/BRIEF.md
# Accumulator High-Word Readout Limiter

This block reads the high word of a wide signed accumulator as a 16-bit value. With the default widths the accumulator has 40 bits and the word read out is bits 31..16. The bits above the word act as guard bits.

A read can be raw or limited. A raw read returns the high word exactly as it stands, even when the guard bits hold significant data. A limited read first checks whether the accumulator fits in a signed 32-bit value. If it does not fit, the word is replaced by the largest positive or the most negative 16-bit value, chosen by the accumulator's sign. If it fits, the two modes return the same word.

A read strobe captures the accumulator and the mode. The result appears on a registered data port together with a one-cycle valid pulse. The data port keeps its last value between reads.

Top module: `acc_lim`

## Requirements
- R1: While `rst_n` is low, `data_o` is 0x0000 and `valid_o` is 0. Reset takes effect without waiting for a clock edge.
- R2: `valid_o` is 1 in exactly the cycles that follow a cycle in which `rd_stb_i` was 1 at the rising edge. It is 0 in every other cycle.
- R3: When `mode_lim_i` is 0 (raw read), the value on `data_o` after the strobe equals `acc_i[31:16]`. This holds whatever the upper bits contain.
- R4: When `mode_lim_i` is 1 (limited read) and `acc_i[39:31]` are all equal, `data_o` equals `acc_i[31:16]`.
- R5: When `mode_lim_i` is 1, `acc_i[39:31]` are not all equal and `acc_i[39]` is 0, `data_o` is 0x7FFF.
- R6: When `mode_lim_i` is 1, `acc_i[39:31]` are not all equal and `acc_i[39]` is 1, `data_o` is 0x8000.
- R7: In a cycle with no strobe, `data_o` keeps its previous value, and `acc_i` and `mode_lim_i` have no effect on it.
- R8: Strobes in consecutive cycles each produce their own result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| acc_i | input | 40 | Signed accumulator value |
| mode_lim_i | input | 1 | Read mode: 0 selects a raw read, 1 selects a limited read |
| rd_stb_i | input | 1 | Read strobe; captures `acc_i` and `mode_lim_i` |
| data_o | output | 16 | Registered readout word |
| valid_o | output | 1 | One-cycle pulse marking a new readout |

## Verification
Each read result, and its valid pulse, is due one clock after the edge that samples the strobe. The reset value is due at once, with no clock. The driver applies inputs on the falling edge and pushes the expected word into a queue. The monitor samples one time unit after each rising edge and pops one entry for every valid pulse, so back-to-back reads are checked in order. Idle cycles are checked against the last word read, and the queue must be empty at the end.

// File: rtl/acc_lim_pkg.sv
package acc_lim_pkg;
  typedef enum logic {
    RD_RAW = 1'b0,
    RD_LIM = 1'b1
  } rd_mode_e;

  localparam int unsigned DEF_ACC_W  = 40;
  localparam int unsigned DEF_OUT_W  = 16;
  localparam int unsigned DEF_HI_LSB = 16;
endpackage

// File: rtl/acc_lim_rst_sync.sv
module acc_lim_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[g] <= 1'b0;
        end else begin
          if (g == 0) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/acc_lim_flags.sv
module acc_lim_flags #(
  parameter int unsigned UP_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input  logic [UP_W-1:0]  acc_up_i,
  output logic [OUT_W-1:0] hi_word_o,
  output logic             ext_o,
  output logic             sign_o
);
  localparam int unsigned GUARD_W = UP_W - OUT_W + 1;

  logic [GUARD_W-1:0] guard;

  always_comb begin
    guard     = acc_up_i[UP_W-1 -: GUARD_W];
    hi_word_o = acc_up_i[OUT_W-1:0];
    sign_o    = acc_up_i[UP_W-1];
    ext_o     = !((&guard) || (~|guard));
  end
endmodule

// File: rtl/acc_lim_sel.sv
module acc_lim_sel
  import acc_lim_pkg::*;
#(
  parameter int unsigned OUT_W = 16
) (
  input  rd_mode_e         mode_i,
  input  logic [OUT_W-1:0] hi_word_i,
  input  logic             ext_i,
  input  logic             sign_i,
  output logic [OUT_W-1:0] word_o
);
  localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MAX_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  always_comb begin
    word_o = hi_word_i;
    if (mode_i == RD_LIM && ext_i) begin
      word_o = sign_i ? MAX_NEG : MAX_POS;
    end
  end
endmodule

// File: rtl/acc_lim_outreg.sv
module acc_lim_outreg #(
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [OUT_W-1:0] word_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  logic [OUT_W-1:0] data_d;
  logic             valid_d;

  always_comb begin
    data_d  = data_o;
    valid_d = en_i;
    if (en_i) data_d = word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      data_o  <= data_d;
      valid_o <= valid_d;
    end
  end
endmodule

// File: rtl/acc_lim.sv
module acc_lim
  import acc_lim_pkg::*;
#(
  parameter int unsigned ACC_W  = DEF_ACC_W,
  parameter int unsigned OUT_W  = DEF_OUT_W,
  parameter int unsigned HI_LSB = DEF_HI_LSB,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             mode_lim_i,
  input  logic             rd_stb_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  localparam int unsigned UP_W = ACC_W - HI_LSB;

  logic             rst_int_n;
  logic [OUT_W-1:0] hi_word;
  logic [OUT_W-1:0] sel_word;
  logic             ext_flag;
  logic             sign_flag;
  rd_mode_e         mode;

  assign mode = rd_mode_e'(mode_lim_i);

  acc_lim_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  acc_lim_flags #(.UP_W(UP_W), .OUT_W(OUT_W)) u_flags (
    .acc_up_i  (acc_i[ACC_W-1:HI_LSB]),
    .hi_word_o (hi_word),
    .ext_o     (ext_flag),
    .sign_o    (sign_flag)
  );

  acc_lim_sel #(.OUT_W(OUT_W)) u_sel (
    .mode_i    (mode),
    .hi_word_i (hi_word),
    .ext_i     (ext_flag),
    .sign_i    (sign_flag),
    .word_o    (sel_word)
  );

  acc_lim_outreg #(.OUT_W(OUT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (rd_stb_i),
    .word_i  (sel_word),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/acc_lim_chk.sv
module acc_lim_chk #(
  parameter int unsigned UP_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [UP_W-1:0]  acc_up,
  input logic             mode_lim_i,
  input logic             rd_stb_i,
  input logic [OUT_W-1:0] data_o,
  input logic             valid_o
);
  localparam int unsigned GW = UP_W - OUT_W + 1;

  logic fits;
  assign fits = (acc_up[UP_W-1 -: GW] == {GW{1'b0}}) ||
                (acc_up[UP_W-1 -: GW] == {GW{1'b1}});

  // R2
  p_valid_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> valid_o);
  p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> !valid_o);
  // R3
  p_raw_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !mode_lim_i) |=> data_o == $past(acc_up[OUT_W-1:0]));
  // R4
  p_fit_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && mode_lim_i && fits) |=> data_o == $past(acc_up[OUT_W-1:0]));
  // R5
  p_clip_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && mode_lim_i && !fits && !acc_up[UP_W-1]) |=>
      data_o == {1'b0, {(OUT_W-1){1'b1}}});
  // R6
  p_clip_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && mode_lim_i && !fits && acc_up[UP_W-1]) |=>
      data_o == {1'b1, {(OUT_W-1){1'b0}}});
  // R7
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(data_o));
endmodule

bind acc_lim acc_lim_chk #(.UP_W(ACC_W - HI_LSB), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_up     (acc_i[ACC_W-1:HI_LSB]),
  .mode_lim_i (mode_lim_i),
  .rd_stb_i   (rd_stb_i),
  .data_o     (data_o),
  .valid_o    (valid_o)
);

// File: tb/acc_lim_tb.sv
module acc_lim_tb;
  logic        clk;
  logic        rst_n;
  logic [39:0] acc_i;
  logic        mode_lim_i;
  logic        rd_stb_i;
  logic [15:0] data_o;
  logic        valid_o;

  int n_tests;
  int n_fail;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_word;

  acc_lim u_dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .mode_lim_i(mode_lim_i),
    .rd_stb_i(rd_stb_i), .data_o(data_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] model(input logic [39:0] a, input logic lim);
    logic fit;
    fit = (a[39:31] == 9'h000) || (a[39:31] == 9'h1FF);
    if (!lim || fit) return a[31:16];
    return a[39] ? 16'h8000 : 16'h7FFF;
  endfunction

  function automatic string req_of(input logic [39:0] a, input logic lim);
    logic fit;
    fit = (a[39:31] == 9'h000) || (a[39:31] == 9'h1FF);
    if (!lim) return "R3";
    if (fit) return "R4";
    return a[39] ? "R6" : "R5";
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: drives on the falling edge and pushes the expected result.
  task automatic drive(input logic [39:0] a, input logic lim);
    @(negedge clk);
    acc_i      = a;
    mode_lim_i = lim;
    rd_stb_i   = 1'b1;
    exp_q.push_back(model(a, lim));
    tag_q.push_back(req_of(a, lim));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_stb_i   = 1'b0;
      acc_i      = 40'h55_AAAA_5555 ^ 40'(i);
      mode_lim_i = i[0];
    end
  endtask

  // Monitor: samples just after every rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && u_mon_en) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check("R2", {15'd0, valid_o}, 16'd0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, data_o, e);
          last_word = e;
        end
      end else begin
        if (exp_q.size() != 0) check("R2", {15'd0, valid_o}, 16'd1);
        check("R7", data_o, last_word);
      end
    end
  end

  logic u_mon_en;

  initial begin
    #(8 * 50000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0; u_mon_en = 1'b0; last_word = 16'h0000;
    rst_n = 1'b0; acc_i = '0; mode_lim_i = 1'b0; rd_stb_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", data_o, 16'h0000);
    check("R1", {15'd0, valid_o}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    u_mon_en = 1'b1;

    drive(40'h00_1234_5678, 1'b0);
    drive(40'h00_1234_5678, 1'b1);
    drive(40'h12_3456_789A, 1'b0);
    drive(40'h12_3456_789A, 1'b1);
    idle(3);
    drive(40'hFF_8000_0000, 1'b1);
    drive(40'h00_7FFF_FFFF, 1'b1);
    drive(40'h00_8000_0000, 1'b1);
    drive(40'h00_8000_0000, 1'b0);
    idle(2);
    drive(40'hFF_0000_1234, 1'b1);
    drive(40'hFF_0000_1234, 1'b0);
    drive(40'h80_0000_0000, 1'b1);
    drive(40'h80_0000_0000, 1'b0);
    drive(40'hFF_FFFF_FFFF, 1'b1);
    drive(40'h7F_FFFF_FFFF, 1'b1);
    // R8: back-to-back run
    for (int i = 0; i < 8; i++) drive({8'(i * 37), 32'hC0DE_0000 + 32'(i << 16)}, i[0]);
    idle(4);
    check("R2", 16'(exp_q.size()), 16'd0);

    // R1: asynchronous reset with no clock edge
    drive(40'h00_4321_0000, 1'b0);
    idle(1);
    u_mon_en = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    check("R1", data_o, 16'h0000);
    check("R1", {15'd0, valid_o}, 16'd0);
    exp_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule